// File: doc/BRIEF.md
# Fixed-Format Instruction Decoder

This block turns one 32-bit instruction word into the register indices, the extended immediate and the control signals that an execution stage needs. Every instruction keeps a 6-bit major code in bits [31:26]. Register fields, the shift distance, the function code and the 16- and 26-bit constants sit at fixed positions, so all of them are extracted in parallel before the format is known. The major code and, for code 0, the function code in bits [5:0] then choose which of those pieces matter.

A word presented with `in_valid` high is decoded and registered. Its results appear on the outputs one clock later, together with `out_valid`. The block covers register-register arithmetic, logic and shifts, immediate arithmetic and logic, the upper-constant load, byte/halfword/word loads and stores, equal and not-equal branches, direct jumps, jump-with-link and register jumps. Any other encoding raises `illegal` and leaves every side effect off.

Top module: `insn_decode`

## Requirements
- R1: Reset clears every output to 0. For a word accepted with `in_valid`=1, its decode appears one clock later with `out_valid`=1. After a cycle with `in_valid`=0, `out_valid`, `reg_we`, `mem_rd`, `mem_wr`, `branch_kind`, `jump_kind` and `illegal` are all 0.
- R2: For every accepted word, `rs_idx`=bits[25:21], `rt_idx`=bits[20:16] and `shamt`=bits[10:6].
- R3: Major code 0 selects the register operation by funct. ADD 0 is selected by 32 and 33, SUB 1 by 34 and 35, AND 2 by 36, OR 3 by 37, XOR 4 by 38, NOR 5 by 39, SLT 6 by 42, SLTU 7 by 43, SLL 8 by 0, SRL 9 by 2 and SRA 10 by 3. Each of these gives `reg_we`=1, `dst_sel`=1 (rd), `dest_idx`=bits[15:11] and `imm_ext`=0.
- R4: Immediate operations write rt (`dst_sel`=0, `dest_idx`=bits[20:16]). Codes 8 and 9 give ADD, 10 gives SLT and 11 gives SLTU, each with the 16-bit constant sign-extended. Codes 12, 13 and 14 give AND, OR and XOR with the constant zero-extended.
- R5: Code 15 writes rt with alu_op LUI 11 and `imm_ext` = {bits[15:0], 16'h0000}.
- R6: Loads have `mem_rd`=1, alu ADD, a sign-extended offset and write rt. Code 32 is a signed byte (size 0), 33 a signed half (size 1), 35 a word (size 2), 36 an unsigned byte and 37 an unsigned half; only 36 and 37 set `mem_unsigned`.
- R7: Stores have `mem_wr`=1, `reg_we`=0, alu ADD and a sign-extended offset. Code 40 stores a byte (size 0), 41 a half (size 1) and 43 a word (size 2).
- R8: Code 4 gives `branch_kind`=1 (equal) and code 5 gives 2 (not equal). Both use alu SUB and a sign-extended displacement and do not write.
- R9: Code 2 gives `jump_kind`=1 with no write. Code 3 gives `jump_kind`=2, `reg_we`=1, `dst_sel`=2 and `dest_idx`=31. For both, `imm_ext` is the 26-bit target zero-extended. Code 0 with funct 8 gives `jump_kind`=3 with no write and `imm_ext`=0.
- R10: Any other code/funct pair sets `illegal`=1 with `reg_we`, `mem_rd`, `mem_wr`, `branch_kind`, `jump_kind`, `alu_op`, `dst_sel`, `dest_idx` and `imm_ext` all 0.
- R11: `mem_rd` and `mem_wr` are never both 1. When neither is set, `mem_size` and `mem_unsigned` are 0. When `reg_we`=0, `dst_sel` and `dest_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word present |
| insn | input | 32 | Instruction word |
| out_valid | output | 1 | Decode results valid |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source / store data register index |
| shamt | output | 5 | Shift distance field |
| dest_idx | output | 5 | Register to write |
| dst_sel | output | 2 | Destination choice: 0 rt, 1 rd, 2 link register |
| reg_we | output | 1 | Register write enable |
| alu_op | output | 4 | Operation code for the ALU |
| imm_ext | output | 32 | Extended immediate or jump target |
| mem_rd | output | 1 | Load |
| mem_wr | output | 1 | Store |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_unsigned | output | 1 | Zero-extend loaded data |
| branch_kind | output | 2 | 0 none, 1 equal, 2 not equal |
| jump_kind | output | 2 | 0 none, 1 direct, 2 direct with link, 3 register |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The assertions assume that `insn` is stable and known on any edge where `in_valid` is high, and that reset is released with `in_valid` low. The bench drives each word half a period before the edge that captures it and lowers `in_valid` between the sweep phases. The stimulus covers all 64 major codes, each with three operand patterns whose immediates have the sign bit both set and clear, plus all 64 function codes under major code 0. The model in the bench rebuilds every expected output from the tables in the requirements.

// File: rtl/insn_decode.sv
module insn_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] insn,
  output logic        out_valid,
  output logic [4:0]  rs_idx,
  output logic [4:0]  rt_idx,
  output logic [4:0]  shamt,
  output logic [4:0]  dest_idx,
  output logic [1:0]  dst_sel,
  output logic        reg_we,
  output logic [3:0]  alu_op,
  output logic [31:0] imm_ext,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [1:0]  mem_size,
  output logic        mem_unsigned,
  output logic [1:0]  branch_kind,
  output logic [1:0]  jump_kind,
  output logic        illegal
);
  localparam logic [3:0] A_ADD = 4'd0, A_SUB = 4'd1, A_AND = 4'd2, A_OR = 4'd3,
                         A_XOR = 4'd4, A_NOR = 4'd5, A_SLT = 4'd6, A_SLTU = 4'd7,
                         A_SLL = 4'd8, A_SRL = 4'd9, A_SRA = 4'd10, A_LUI = 4'd11;
  localparam logic [1:0] SEL_RT = 2'd0, SEL_RD = 2'd1, SEL_LINK = 2'd2;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;
  localparam logic [4:0] LINK_REG = 5'd31;

  logic [5:0]  op, fn;
  logic [15:0] k16;
  logic [31:0] k_sx, k_zx, k_hi, k_tgt;

  assign op    = insn[31:26];
  assign fn    = insn[5:0];
  assign k16   = insn[15:0];
  assign k_sx  = {{16{k16[15]}}, k16};
  assign k_zx  = {16'h0000, k16};
  assign k_hi  = {k16, 16'h0000};
  assign k_tgt = {6'd0, insn[25:0]};

  logic        n_we, n_rd, n_wr, n_uns, n_ill;
  logic [1:0]  n_sel, n_size, n_br, n_jmp;
  logic [3:0]  n_alu;
  logic [31:0] n_imm;
  logic [4:0]  n_dest;

  always_comb begin
    n_we = 1'b0; n_sel = SEL_RT; n_alu = A_ADD; n_imm = '0;
    n_rd = 1'b0; n_wr = 1'b0; n_size = SZ_B; n_uns = 1'b0;
    n_br = 2'd0; n_jmp = 2'd0; n_ill = 1'b0;
    case (op)
      6'd0: begin
        n_we = 1'b1; n_sel = SEL_RD;
        case (fn)
          6'd0:  n_alu = A_SLL;
          6'd2:  n_alu = A_SRL;
          6'd3:  n_alu = A_SRA;
          6'd32, 6'd33: n_alu = A_ADD;
          6'd34, 6'd35: n_alu = A_SUB;
          6'd36: n_alu = A_AND;
          6'd37: n_alu = A_OR;
          6'd38: n_alu = A_XOR;
          6'd39: n_alu = A_NOR;
          6'd42: n_alu = A_SLT;
          6'd43: n_alu = A_SLTU;
          6'd8: begin
            n_we = 1'b0; n_sel = SEL_RT; n_jmp = 2'd3;
          end
          default: begin
            n_we = 1'b0; n_sel = SEL_RT; n_ill = 1'b1;
          end
        endcase
      end
      6'd2: begin n_jmp = 2'd1; n_imm = k_tgt; end
      6'd3: begin n_jmp = 2'd2; n_imm = k_tgt; n_we = 1'b1; n_sel = SEL_LINK; end
      6'd4: begin n_br = 2'd1; n_alu = A_SUB; n_imm = k_sx; end
      6'd5: begin n_br = 2'd2; n_alu = A_SUB; n_imm = k_sx; end
      6'd8, 6'd9: begin n_we = 1'b1; n_alu = A_ADD; n_imm = k_sx; end
      6'd10: begin n_we = 1'b1; n_alu = A_SLT;  n_imm = k_sx; end
      6'd11: begin n_we = 1'b1; n_alu = A_SLTU; n_imm = k_sx; end
      6'd12: begin n_we = 1'b1; n_alu = A_AND;  n_imm = k_zx; end
      6'd13: begin n_we = 1'b1; n_alu = A_OR;   n_imm = k_zx; end
      6'd14: begin n_we = 1'b1; n_alu = A_XOR;  n_imm = k_zx; end
      6'd15: begin n_we = 1'b1; n_alu = A_LUI;  n_imm = k_hi; end
      6'd32: begin n_we = 1'b1; n_rd = 1'b1; n_imm = k_sx; n_size = SZ_B; end
      6'd33: begin n_we = 1'b1; n_rd = 1'b1; n_imm = k_sx; n_size = SZ_H; end
      6'd35: begin n_we = 1'b1; n_rd = 1'b1; n_imm = k_sx; n_size = SZ_W; end
      6'd36: begin n_we = 1'b1; n_rd = 1'b1; n_imm = k_sx; n_size = SZ_B; n_uns = 1'b1; end
      6'd37: begin n_we = 1'b1; n_rd = 1'b1; n_imm = k_sx; n_size = SZ_H; n_uns = 1'b1; end
      6'd40: begin n_wr = 1'b1; n_imm = k_sx; n_size = SZ_B; end
      6'd41: begin n_wr = 1'b1; n_imm = k_sx; n_size = SZ_H; end
      6'd43: begin n_wr = 1'b1; n_imm = k_sx; n_size = SZ_W; end
      default: n_ill = 1'b1;
    endcase
  end

  always_comb begin
    case (n_sel)
      SEL_RD:   n_dest = insn[15:11];
      SEL_LINK: n_dest = LINK_REG;
      default:  n_dest = n_we ? insn[20:16] : 5'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; rs_idx <= '0; rt_idx <= '0; shamt <= '0;
      dest_idx <= '0; dst_sel <= '0; reg_we <= 1'b0; alu_op <= '0;
      imm_ext <= '0; mem_rd <= 1'b0; mem_wr <= 1'b0; mem_size <= '0;
      mem_unsigned <= 1'b0; branch_kind <= '0; jump_kind <= '0; illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rs_idx       <= insn[25:21];
        rt_idx       <= insn[20:16];
        shamt        <= insn[10:6];
        dest_idx     <= n_dest;
        dst_sel      <= n_sel;
        reg_we       <= n_we;
        alu_op       <= n_alu;
        imm_ext      <= n_imm;
        mem_rd       <= n_rd;
        mem_wr       <= n_wr;
        mem_size     <= n_size;
        mem_unsigned <= n_uns;
        branch_kind  <= n_br;
        jump_kind    <= n_jmp;
        illegal      <= n_ill;
      end else begin
        reg_we <= 1'b0; mem_rd <= 1'b0; mem_wr <= 1'b0;
        branch_kind <= '0; jump_kind <= '0; illegal <= 1'b0;
        dst_sel <= '0; dest_idx <= '0; mem_size <= '0; mem_unsigned <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/insn_decode_chk.sv
module insn_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] insn,
  input logic        out_valid,
  input logic [4:0]  rs_idx,
  input logic [4:0]  rt_idx,
  input logic [4:0]  dest_idx,
  input logic [1:0]  dst_sel,
  input logic        reg_we,
  input logic [3:0]  alu_op,
  input logic [31:0] imm_ext,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [1:0]  mem_size,
  input logic        mem_unsigned,
  input logic [1:0]  branch_kind,
  input logic [1:0]  jump_kind,
  input logic        illegal
);
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !reg_we && !mem_rd && !mem_wr && branch_kind == 2'd0 && jump_kind == 2'd0 && !illegal)); // R1
  AST_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (rs_idx == $past(insn[25:21]) && rt_idx == $past(insn[20:16]))); // R2
  AST_LUI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && alu_op == 4'd11) |-> imm_ext[15:0] == 16'h0000); // R5
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> !reg_we); // R7
  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_kind != 2'd0) |-> (!reg_we && jump_kind == 2'd0)); // R8
  AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_kind == 2'd2) |-> (reg_we && dest_idx == 5'd31)); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!reg_we && !mem_rd && !mem_wr && branch_kind == 2'd0 && jump_kind == 2'd0 && imm_ext == 32'd0)); // R10
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R11
  AST_NO_MEM_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |-> (mem_size == 2'd0 && !mem_unsigned)); // R11
  AST_NO_WE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> (dest_idx == 5'd0 && dst_sel == 2'd0)); // R11
endmodule

bind insn_decode insn_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .out_valid(out_valid),
  .rs_idx(rs_idx), .rt_idx(rt_idx), .dest_idx(dest_idx), .dst_sel(dst_sel),
  .reg_we(reg_we), .alu_op(alu_op), .imm_ext(imm_ext), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_size(mem_size), .mem_unsigned(mem_unsigned), .branch_kind(branch_kind),
  .jump_kind(jump_kind), .illegal(illegal)
);

// File: tb/insn_decode_test.sv
module insn_decode_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic out_valid, reg_we, mem_rd, mem_wr, mem_unsigned, illegal;
  logic [4:0] rs_idx, rt_idx, shamt, dest_idx;
  logic [1:0] dst_sel, mem_size, branch_kind, jump_kind;
  logic [3:0] alu_op;
  logic [31:0] imm_ext;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  insn_decode uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .out_valid(out_valid),
    .rs_idx(rs_idx), .rt_idx(rt_idx), .shamt(shamt), .dest_idx(dest_idx), .dst_sel(dst_sel),
    .reg_we(reg_we), .alu_op(alu_op), .imm_ext(imm_ext), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_size(mem_size), .mem_unsigned(mem_unsigned), .branch_kind(branch_kind),
    .jump_kind(jump_kind), .illegal(illegal)
  );

  function automatic logic [53:0] got_vec();
    return {reg_we, dst_sel, dest_idx, alu_op, mem_rd, mem_wr, mem_size, mem_unsigned,
            branch_kind, jump_kind, illegal, imm_ext};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    int op = w[31:26];
    if (op == 0) return (w[5:0] == 6'd8) ? "R9" : "R3";
    if (op == 15) return "R5";
    if (op >= 8 && op <= 14) return "R4";
    if (op == 32 || op == 33 || op == 35 || op == 36 || op == 37) return "R6";
    if (op == 40 || op == 41 || op == 43) return "R7";
    if (op == 4 || op == 5) return "R8";
    if (op == 2 || op == 3) return "R9";
    return "R10";
  endfunction

  function automatic logic [53:0] exp_vec(input logic [31:0] w);
    logic we = 0, rd = 0, wr = 0, uns = 0, ill = 0;
    logic [1:0] sel = 0, sz = 0, br = 0, jk = 0;
    logic [3:0] alu = 0;
    logic [4:0] dst = 0;
    logic [31:0] imm = 0;
    logic [31:0] sx = {{16{w[15]}}, w[15:0]};
    int op = w[31:26];
    int fn = w[5:0];
    case (op)
      0: begin
        we = 1; sel = 1; dst = w[15:11];
        case (fn)
          0: alu = 8; 2: alu = 9; 3: alu = 10;
          32, 33: alu = 0; 34, 35: alu = 1; 36: alu = 2; 37: alu = 3;
          38: alu = 4; 39: alu = 5; 42: alu = 6; 43: alu = 7;
          8: begin we = 0; sel = 0; dst = 0; jk = 3; end
          default: begin we = 0; sel = 0; dst = 0; ill = 1; end
        endcase
      end
      2: begin jk = 1; imm = {6'd0, w[25:0]}; end
      3: begin jk = 2; imm = {6'd0, w[25:0]}; we = 1; sel = 2; dst = 31; end
      4: begin br = 1; alu = 1; imm = sx; end
      5: begin br = 2; alu = 1; imm = sx; end
      8, 9, 10, 11: begin we = 1; dst = w[20:16]; imm = sx; alu = (op == 10) ? 4'd6 : (op == 11) ? 4'd7 : 4'd0; end
      12, 13, 14: begin we = 1; dst = w[20:16]; imm = {16'd0, w[15:0]}; alu = 4'(op - 10); end
      15: begin we = 1; dst = w[20:16]; imm = {w[15:0], 16'd0}; alu = 11; end
      32, 33, 35, 36, 37: begin
        we = 1; dst = w[20:16]; rd = 1; imm = sx;
        sz = (op == 35) ? 2'd2 : (op == 33 || op == 37) ? 2'd1 : 2'd0;
        uns = (op >= 36);
      end
      40, 41, 43: begin wr = 1; imm = sx; sz = (op == 43) ? 2'd2 : (op == 41) ? 2'd1 : 2'd0; end
      default: ill = 1;
    endcase
    return {we, sel, dst, alu, rd, wr, sz, uns, br, jk, ill, imm};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (insn %h)", req, act, exp, insn);
    end
  endtask

  task automatic apply_and_check(input logic [31:0] w);
    @(negedge clk);
    insn = w; in_valid = 1'b1;
    @(negedge clk);
    check("R1", 64'(out_valid), 64'd1);
    check("R2", 64'({rs_idx, rt_idx, shamt}), 64'({w[25:21], w[20:16], w[10:6]}));
    check(tag_of(w), 64'(got_vec()), 64'(exp_vec(w)));
    check("R11", 64'({mem_rd & mem_wr, (!mem_rd && !mem_wr) ? {mem_size, mem_unsigned} : 3'd0}), 64'd0);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0; insn = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R1", 64'({out_valid, reg_we, mem_rd, mem_wr, branch_kind, jump_kind, illegal}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 64'(got_vec()), 64'd0);
    check("R1", 64'({out_valid, rs_idx, rt_idx, shamt}), 64'd0);
    rst_n = 1'b1;
    idle_check();
    for (int op = 0; op < 64; op++) begin
      apply_and_check({6'(op), 5'd3, 5'd17, 16'h8001});
      apply_and_check({6'(op), 5'd31, 5'd0, 16'h7FFE});
      apply_and_check({6'(op), 5'd9, 5'd22, 16'hFFFF});
    end
    idle_check();
    for (int fn = 0; fn < 64; fn++)
      apply_and_check({6'd0, 5'd5, 5'd12, 5'd30, 5'd7, 6'(fn)});
    apply_and_check({6'd3, 26'h3FF_FFFF});
    apply_and_check({6'd15, 5'd0, 5'd4, 16'h8000});
    idle_check();
    idle_check();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule